// File: doc/BRIEF.md
# Read-Enable Alignment with Trained Depth

A DDR2 memory returns read data with no strobe that marks which captured words are valid. This block builds that valid strobe locally. It takes the read enable that the controller derives from CAS latency and burst length and passes it through a tapped delay line of up to sixteen stages. The delayed enable leaves the block as a data-valid flag that lines up with the parallel words coming out of the capture logic.

The delay is not fixed at design time. It is learned once, after the capture path has been tuned. The controller raises the training-start input while it issues dummy reads of a known word. It presents that word on the pattern input. The block waits for the first rising edge of the read enable. It then counts divided-clock cycles until the captured word equals the pattern, and that count becomes the tap select. When no match arrives inside the sixteen-cycle window, a failure flag is raised and done stays low. After training has succeeded, every read enable, including back-to-back bursts, is reproduced on data-valid exactly that many cycles later.

Top module: `rden_align`

## Requirements
- R1: While reset is high, and in the first cycle after it, data_valid_o, cal_done_o and cal_fail_o are 0.
- R2: While training has not started (train_start_i low since reset), read enables and captured words have no effect: cal_done_o and data_valid_o stay 0.
- R3: Once train_start_i is high, measurement begins only at a rising edge of rd_en_i (high in a cycle where it was low the cycle before). A matching word that arrives before that edge is ignored.
- R4: A match means that all DATA_W bits of cap_data_i equal train_pattern_i. The trained depth is the number of cycles from the edge cycle to the first match cycle, which is 0 when both fall in the same cycle. cal_done_o rises in the cycle after the match cycle.
- R5: If no match occurs at offsets 0 to 15 after the edge, cal_fail_o rises in the cycle after offset 15 and cal_done_o stays 0.
- R6: After cal_done_o is high, data_valid_o in each cycle equals rd_en_i from exactly depth cycles earlier, with no gaps or extra pulses across back-to-back enables.
- R7: data_valid_o is 0 whenever cal_done_o is 0, including after a failed training.
- R8: Dropping train_start_i before done or fail aborts training, even in a cycle that holds a match. A later assertion of train_start_i measures afresh from the next rising edge. cal_done_o can only rise after a cycle with train_start_i high.
- R9: cal_done_o and cal_fail_o are never high together, and once set, each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read enable from the controller |
| cap_data_i | input | DATA_W | Parallel word from the read capture logic |
| train_start_i | input | 1 | High while dummy training reads are in progress |
| train_pattern_i | input | DATA_W | Word expected in the captured data during training |
| data_valid_o | output | 1 | Read enable delayed by the trained depth |
| cal_done_o | output | 1 | Training finished and a depth was stored |
| cal_fail_o | output | 1 | No match arrived inside the sixteen-cycle window |

## Verification
Training is run with the matching word placed at offsets 0, 1, 3, 7 and 15 after the enable edge, and at offset 16. These tell apart the same-cycle case, an off-by-one in the counter, the last tap that is allowed and the timeout. Each trained depth is then probed with enable sequences that mix isolated pulses, gapped bursts and long back-to-back runs. This exposes a wrong tap, a dropped cycle between adjacent bursts or an extra pulse. Directed runs place the matching word before the enable edge, drop the start input in the same cycle as a match and send reads while training is idle. These separate a correct edge-qualified, start-gated measurement from one that triggers on any match.

// File: rtl/rdal_pkg.sv
package rdal_pkg;

    localparam int unsigned RDAL_DATA_W    = 16;
    localparam int unsigned RDAL_MAX_DEPTH = 16;

    typedef enum logic [2:0] {
        TR_IDLE,
        TR_ARMED,
        TR_COUNT,
        TR_DONE,
        TR_FAIL
    } train_state_e;

    typedef struct packed {
        logic done;
        logic fail;
    } train_status_t;

    function automatic int unsigned sel_width(input int unsigned stages);
        return (stages > 1) ? $clog2(stages) : 1;
    endfunction

endpackage

// File: rtl/rdal_match.sv
module rdal_match #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [DATA_W-1:0] ref_i,
    output logic              eq_o
);
    logic [DATA_W-1:0] bit_eq;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bit_eq[b] = ~(word_i[b] ^ ref_i[b]);
    end

    assign eq_o = &bit_eq;
endmodule

// File: rtl/rdal_train.sv
module rdal_train
    import rdal_pkg::*;
#(
    parameter int unsigned STAGES = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             en_i,
    input  logic             match_i,
    output logic [SEL_W-1:0] depth_o,
    output train_status_t    status_o
);
    localparam logic [SEL_W-1:0] LAST_OFS = SEL_W'(STAGES - 1);

    train_state_e     st_q, st_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] dep_q, dep_d;
    logic             en_q;
    logic             en_rise;

    assign en_rise = en_i & ~en_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        dep_d = dep_q;
        unique case (st_q)
            TR_IDLE: begin
                if (start_i) st_d = TR_ARMED;
            end
            TR_ARMED: begin
                if (!start_i) begin
                    st_d = TR_IDLE;
                end else if (en_rise) begin
                    if (match_i) begin
                        dep_d = '0;
                        st_d  = TR_DONE;
                    end else begin
                        cnt_d = SEL_W'(1);
                        st_d  = TR_COUNT;
                    end
                end
            end
            TR_COUNT: begin
                if (!start_i) begin
                    st_d = TR_IDLE;
                end else if (match_i) begin
                    dep_d = cnt_q;
                    st_d  = TR_DONE;
                end else if (cnt_q == LAST_OFS) begin
                    st_d = TR_FAIL;
                end else begin
                    cnt_d = cnt_q + SEL_W'(1);
                end
            end
            TR_DONE: st_d = TR_DONE;
            TR_FAIL: st_d = TR_FAIL;
            default: st_d = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TR_IDLE;
            cnt_q <= '0;
            dep_q <= '0;
            en_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            dep_q <= dep_d;
            en_q  <= en_i;
        end
    end

    assign depth_o       = dep_q;
    assign status_o.done = (st_q == TR_DONE);
    assign status_o.fail = (st_q == TR_FAIL);
endmodule

// File: rtl/rdal_delay.sv
module rdal_delay #(
    parameter int unsigned STAGES = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             gate_i,
    output logic             valid_o
);
    logic [STAGES-1:0] taps;

    assign taps[0] = en_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        logic stage_q;
        always_ff @(posedge clk) begin
            if (rst) stage_q <= 1'b0;
            else     stage_q <= taps[s-1];
        end
        assign taps[s] = stage_q;
    end

    assign valid_o = gate_i & taps[sel_i];
endmodule

// File: rtl/rden_align.sv
module rden_align
    import rdal_pkg::*;
#(
    parameter int unsigned DATA_W    = RDAL_DATA_W,
    parameter int unsigned MAX_DEPTH = RDAL_MAX_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] cap_data_i,
    input  logic              train_start_i,
    input  logic [DATA_W-1:0] train_pattern_i,
    output logic              data_valid_o,
    output logic              cal_done_o,
    output logic              cal_fail_o
);
    localparam int unsigned SEL_W = sel_width(MAX_DEPTH);

    logic             word_eq;
    logic [SEL_W-1:0] cal_depth;
    train_status_t    status;

    rdal_match #(.DATA_W(DATA_W)) i_match (
        .word_i (cap_data_i),
        .ref_i  (train_pattern_i),
        .eq_o   (word_eq)
    );

    rdal_train #(.STAGES(MAX_DEPTH), .SEL_W(SEL_W)) i_train (
        .clk      (clk),
        .rst      (rst),
        .start_i  (train_start_i),
        .en_i     (rd_en_i),
        .match_i  (word_eq),
        .depth_o  (cal_depth),
        .status_o (status)
    );

    rdal_delay #(.STAGES(MAX_DEPTH), .SEL_W(SEL_W)) i_delay (
        .clk     (clk),
        .rst     (rst),
        .en_i    (rd_en_i),
        .sel_i   (cal_depth),
        .gate_i  (status.done),
        .valid_o (data_valid_o)
    );

    assign cal_done_o = status.done;
    assign cal_fail_o = status.fail;
endmodule

// File: rtl/rden_align_chk.sv
module rden_align_chk #(
    parameter int unsigned SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             train_start,
    input logic             data_valid,
    input logic             cal_done,
    input logic             cal_fail,
    input logic [SEL_W-1:0] depth
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!data_valid && !cal_done && !cal_fail));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && cal_fail));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done);

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_fail |=> cal_fail);

    a_r7_no_valid_untrained: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> !data_valid);

    a_r8_done_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> $past(train_start));

    a_r6_depth_zero: assert property (@(posedge clk) disable iff (rst)
        (cal_done && depth == '0) |-> (data_valid == rd_en));

    a_r6_depth_one: assert property (@(posedge clk) disable iff (rst)
        (cal_done && $past(cal_done) && depth == SEL_W'(1)) |-> (data_valid == $past(rd_en)));
endmodule

bind rden_align rden_align_chk #(.SEL_W(SEL_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en_i),
    .train_start (train_start_i),
    .data_valid  (data_valid_o),
    .cal_done    (cal_done_o),
    .cal_fail    (cal_fail_o),
    .depth       (cal_depth)
);

// File: tb/test_rden_align.sv
module test_rden_align;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] cap = '0;
    logic        start = 1'b0;
    logic [15:0] pat = 16'h0;
    logic        valid, done, fail;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rden_align i_rden_align (
        .clk             (clk),
        .rst             (rst),
        .rd_en_i         (rd_en),
        .cap_data_i      (cap),
        .train_start_i   (start),
        .train_pattern_i (pat),
        .data_valid_o    (valid),
        .cal_done_o      (done),
        .cal_fail_o      (fail)
    );

    // {match offset, pattern, enable sequence (bit t = cycle t)}
    localparam logic [52:0] VECS [0:5] = '{
        {5'd0,  16'hA5C3, 32'h0000_0FF0},
        {5'd1,  16'h3C96, 32'h0003_3330},
        {5'd3,  16'hFFFF, 32'h00F0_F0F0},
        {5'd7,  16'h0001, 32'h0000_0FFF},
        {5'd15, 16'h8000, 32'h0000_0F0F},
        {5'd16, 16'h1234, 32'h0000_00FF}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; rd_en = 1'b0; cap = '0;
        next_cycle(); next_cycle();
        rst = 1'b0;
    endtask

    // One idle cycle with start high, then an enable pulse of two cycles with the
    // match at offset k; the other cycles carry non-matching words.
    task automatic run_cal(input int k, input logic [15:0] p);
        pat = p; start = 1'b1; rd_en = 1'b0; cap = ~p;
        next_cycle();
        for (int c = 0; c <= 20; c++) begin
            rd_en = (c < 2);
            cap   = (c == k) ? p : (p ^ 16'(c + 1));
            @(negedge clk);
            if (k < 16 && c == k)     chk("R4", "done before match seen", done, 1'b0);
            if (k < 16 && c == k + 1) chk("R4", "done after match", done, 1'b1);
            if (k >= 16 && c == 15)   chk("R5", "fail early", fail, 1'b0);
            if (k >= 16 && c == 16)   chk("R5", "fail after window", fail, 1'b1);
            next_cycle();
        end
        start = 1'b0;
    endtask

    task automatic probe_depth(input int k, input logic trained);
        rd_en = 1'b0;
        repeat (17) next_cycle();
        for (int t = 0; t < 20; t++) begin
            rd_en = (t == 0);
            @(negedge clk);
            chk(trained ? "R6" : "R7", "single pulse", valid, trained && (t == k));
            next_cycle();
        end
        rd_en = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1", "valid after reset", valid, 1'b0);
        chk("R1", "done after reset", done, 1'b0);
        chk("R1", "fail after reset", fail, 1'b0);
        next_cycle();

        // Vector table: trained depth, then an enable sequence
        for (int v = 0; v < 6; v++) begin
            int          k;
            logic [15:0] p;
            logic [31:0] seq;
            {k, p, seq} = {27'd0, VECS[v]};
            do_reset();
            run_cal(k, p);
            @(negedge clk);
            chk("R9", "done sticky after start drop", done, k < 16);
            chk("R9", "fail sticky after start drop", fail, k >= 16);
            next_cycle();
            for (int t = 0; t < 48; t++) begin
                logic exp;
                rd_en = (t < 32) ? seq[t] : 1'b0;
                exp = (k < 16 && t >= k && (t - k) < 32) ? seq[t - k] : 1'b0;
                @(negedge clk);
                chk(k < 16 ? "R6" : "R7", "delayed enable", valid, exp);
                next_cycle();
            end
            rd_en = 1'b0;
        end

        // R2: reads and matching data while training is idle
        do_reset();
        pat = 16'h5A5A;
        for (int t = 0; t < 20; t++) begin
            rd_en = (t % 3 == 0);
            cap   = pat;
            @(negedge clk);
            chk("R2", "valid while idle", valid, 1'b0);
            next_cycle();
        end
        chk("R2", "done while idle", done, 1'b0);
        rd_en = 1'b0;

        // R3: match before the enable edge is ignored
        do_reset();
        pat = 16'hC33C; start = 1'b1; rd_en = 1'b0; cap = pat;
        for (int t = 0; t < 6; t++) begin
            next_cycle();
            @(negedge clk);
            chk("R3", "done without edge", done, 1'b0);
        end
        next_cycle();
        rd_en = 1'b1; cap = ~pat; next_cycle();
        rd_en = 1'b1; cap = ~pat; next_cycle();
        rd_en = 1'b0; cap = pat;  next_cycle();
        cap = ~pat;
        @(negedge clk);
        chk("R3", "done after edge-relative match", done, 1'b1);
        next_cycle();
        start = 1'b0;
        probe_depth(2, 1'b1);

        // R8: abort in the same cycle as a match, then retrain
        do_reset();
        pat = 16'h0F0F; start = 1'b1; rd_en = 1'b0; cap = ~pat;
        next_cycle();
        rd_en = 1'b1; next_cycle();
        rd_en = 1'b1; next_cycle();
        rd_en = 1'b0; next_cycle();
        start = 1'b0; cap = pat; next_cycle();
        cap = ~pat;
        @(negedge clk);
        chk("R8", "done after abort", done, 1'b0);
        chk("R8", "fail after abort", fail, 1'b0);
        next_cycle();
        next_cycle();
        run_cal(4, 16'hBEEF);
        @(negedge clk);
        chk("R8", "done after retrain", done, 1'b1);
        next_cycle();
        probe_depth(4, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule